// File: doc/BRIEF.md
# Tap Window Selector

This block picks the sampling phase, or tap, for the receive data path of a high-speed SD/eMMC host once a tuning sweep has finished. Firmware or a sequencer probes every one of the N taps twice. It packs the pass/fail results into a 2N-bit bitmap and pulses `start_i`. Bit i and bit i+N hold the two probes of tap i. The block folds the two passes together so that a tap counts only when both of its probes passed. It then walks the 2N positions one bit per clock and tracks the longest stretch of passing positions. Because the stretch may run past position N-1, a window that wraps around the tap ring is still found.

When the best stretch is long enough, the tap at its centre, reduced modulo N, is written to `tap_set_o` and automatic retuning is enabled. When the stretch is too short, the block flags an error and leaves the previous tap in place. In the four-tap high-speed-400 variant, the programmed tap is half of the selected one. A separate retune-error flag is set by the data path and cleared whenever a new scan is accepted.

Top module: `tap_window_sel`

## Requirements
- R1: Position i (i < N) and position i+N both count as passing only when bitmap bits i and i+N are both 1. If either bit is 0, both positions count as failing.
- R2: The scan measures the longest run of consecutive passing positions over positions 0 to 2N-1, and a run that ends at position 2N-1 is included.
- R3: Among runs of equal length, the one that starts earliest is kept.
- R4: If the longest run is shorter than 3 positions, `err_o` is 1 at completion, `retune_en_o` is 0 and `tap_set_o` keeps its previous value.
- R5: On success the selected tap is ((run_start + run_end) / 2) mod N, where run_end = run_start + length - 1 and the division truncates.
- R6: When `hs400_4tap_i` was 1 at start, the programmed tap is the selected tap shifted right by one bit.
- R7: On success `tap_set_o` takes the programmed tap, `err_o` is 0 and `retune_en_o` is 1 from the completion cycle onwards.
- R8: A 1 on `retune_err_set_i` sets `retune_err_o`, which holds until a start is accepted. An accepted start clears it, and this clear wins over a set in the same cycle.
- R9: `done_o` is high for exactly one cycle, in the cycle after the 2N+2nd rising edge that follows the edge accepting the start. `busy_o` is high from the accepting edge until that completion edge.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. It changes neither the running scan nor its result.
- R11: After reset `busy_o`, `done_o`, `err_o`, `retune_en_o`, `retune_err_o` and `tap_set_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, accepted only while idle |
| tap_count_i | input | $clog2(MAX_TAPS+1) | Number of taps N, 1 to MAX_TAPS |
| hs400_4tap_i | input | 1 | Halve the selected tap (four-tap high-speed-400 variant) |
| bitmap_i | input | 2*MAX_TAPS | Probe results, bit i and bit i+N for tap i |
| retune_err_set_i | input | 1 | Sets the retune-error flag |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last scan found no run of at least 3 |
| tap_set_o | output | $clog2(MAX_TAPS) | Programmed sampling tap |
| retune_en_o | output | 1 | Automatic retune enabled |
| retune_err_o | output | 1 | Retune-error flag |

## Verification
The properties assume that `tap_count_i` lies between 1 and MAX_TAPS whenever a start is accepted. The completion-time check and the tap-range check both measure against the N captured at that edge. No assumption is made about `bitmap_i` after the start, because the block latches it. The stimulus only ever presents N of 4 or 8. It sweeps every bitmap for N = 4 in both the normal and the halving variant, and it drives a few hundred dense random bitmaps for N = 8. Directed cases cover tied runs, a run that wraps, the error path and a start request made in mid-scan.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    TWS_IDLE  = 2'd0,
    TWS_MERGE = 2'd1,
    TWS_SCAN  = 2'd2,
    TWS_FINAL = 2'd3
  } tws_state_e;
endpackage

// File: rtl/tws_rst_sync.sv
module tws_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tws_merge.sv
// Folds the two probe passes: a position survives only if its twin passed too.
module tws_merge #(
  parameter  int MAX_TAPS = 8,
  localparam int BMW      = 2 * MAX_TAPS,
  localparam int NW       = $clog2(MAX_TAPS + 1)
) (
  input  logic [BMW-1:0] raw_i,
  input  logic [NW-1:0]  n_i,
  output logic [BMW-1:0] merged_o
);
  logic [BMW-1:0] twin_up;
  logic [BMW-1:0] twin_dn;
  logic [NW:0]    lo_lim;
  logic [NW:0]    hi_lim;

  assign twin_up = raw_i >> n_i;
  assign twin_dn = raw_i << n_i;
  assign lo_lim  = {1'b0, n_i};
  assign hi_lim  = {n_i, 1'b0};

  for (genvar g = 0; g < BMW; g++) begin : g_pos
    localparam logic [NW:0] POS = (NW + 1)'(g);
    logic in_lo;
    logic in_hi;
    assign in_lo = POS < lo_lim;
    assign in_hi = POS < hi_lim;
    assign merged_o[g] = in_lo ? (raw_i[g] & twin_up[g]) :
                         in_hi ? (raw_i[g] & twin_dn[g]) : 1'b0;
  end
endmodule

// File: rtl/tws_scan.sv
// Run-length tracker: one bitmap position per enabled cycle.
module tws_scan #(
  parameter  int MAX_TAPS = 8,
  localparam int IW       = $clog2(2 * MAX_TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          bit_i,
  input  logic [IW-1:0] idx_i,
  output logic [IW-1:0] run_o,
  output logic [IW-1:0] best_cnt_o,
  output logic [IW-1:0] best_start_o
);
  logic [IW-1:0] run_q,   run_d;
  logic [IW-1:0] cnt_q,   cnt_d;
  logic [IW-1:0] start_q, start_d;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    if (clr_i) begin
      run_d   = '0;
      cnt_d   = '0;
      start_d = '0;
    end else if (en_i) begin
      if (bit_i) begin
        run_d = run_q + IW'(1);
      end else begin
        if (run_q > cnt_q) begin
          cnt_d   = run_q;
          start_d = idx_i - run_q;
        end
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign run_o        = run_q;
  assign best_cnt_o   = cnt_q;
  assign best_start_o = start_q;
endmodule

// File: rtl/tws_pick.sv
// Closes a run that reaches the last position and derives the centre tap.
module tws_pick #(
  parameter  int MAX_TAPS = 8,
  parameter  int MIN_RUN  = 3,
  localparam int NW       = $clog2(MAX_TAPS + 1),
  localparam int IW       = $clog2(2 * MAX_TAPS + 1),
  localparam int TW       = $clog2(MAX_TAPS),
  localparam int SW       = IW + 2
) (
  input  logic [NW-1:0] n_i,
  input  logic          half_i,
  input  logic [IW-1:0] run_i,
  input  logic [IW-1:0] best_cnt_i,
  input  logic [IW-1:0] best_start_i,
  output logic [TW-1:0] tap_o,
  output logic          ok_o
);
  logic          tail_wins;
  logic [IW-1:0] cnt;
  logic [IW-1:0] st;
  logic [SW-1:0] span;
  logic [SW-1:0] sum;
  logic [SW-1:0] mid;
  logic [SW-1:0] md;
  logic [SW-1:0] n_ext;
  logic [TW-1:0] tap_full;

  always_comb begin
    n_ext     = SW'(n_i);
    span      = n_ext + n_ext;
    tail_wins = run_i > best_cnt_i;
    cnt       = tail_wins ? run_i : best_cnt_i;
    st        = tail_wins ? IW'(span - SW'(run_i)) : best_start_i;
    sum       = SW'(st) + SW'(st) + SW'(cnt) - SW'(1);
    mid       = sum >> 1;
    md        = (mid >= n_ext) ? (mid - n_ext) : mid;
    tap_full  = TW'(md);
    tap_o     = half_i ? (tap_full >> 1) : tap_full;
    ok_o      = cnt >= IW'(MIN_RUN);
  end
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel #(
  parameter  int MAX_TAPS = 8,
  parameter  int MIN_RUN  = 3,
  localparam int BMW      = 2 * MAX_TAPS,
  localparam int NW       = $clog2(MAX_TAPS + 1),
  localparam int IW       = $clog2(2 * MAX_TAPS + 1),
  localparam int TW       = $clog2(MAX_TAPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [NW-1:0]  tap_count_i,
  input  logic           hs400_4tap_i,
  input  logic [BMW-1:0] bitmap_i,
  input  logic           retune_err_set_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [TW-1:0]  tap_set_o,
  output logic           retune_en_o,
  output logic           retune_err_o
);
  import tws_pkg::*;

  logic           rst_sn;
  tws_state_e     state_q,  state_d;
  logic [BMW-1:0] raw_q,    raw_d;
  logic [BMW-1:0] merged_q, merged_d;
  logic [NW-1:0]  n_q,      n_d;
  logic           half_q,   half_d;
  logic [IW-1:0]  idx_q,    idx_d;
  logic [TW-1:0]  tap_q,    tap_d;
  logic           err_q,    err_d;
  logic           ren_q,    ren_d;
  logic           done_q,   done_d;
  logic           rerr_q,   rerr_d;

  logic           accept;
  logic [BMW-1:0] merged_w;
  logic [BMW-1:0] scan_sh;
  logic [IW-1:0]  last_idx;
  logic [IW-1:0]  run_w, best_cnt_w, best_start_w;
  logic [TW-1:0]  pick_tap;
  logic           pick_ok;
  logic           scan_clr, scan_en;

  tws_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  tws_merge #(.MAX_TAPS(MAX_TAPS)) u_merge (
    .raw_i    (raw_q),
    .n_i      (n_q),
    .merged_o (merged_w)
  );

  assign scan_clr = state_q == TWS_MERGE;
  assign scan_en  = state_q == TWS_SCAN;
  assign scan_sh  = merged_q >> idx_q;

  tws_scan #(.MAX_TAPS(MAX_TAPS)) u_scan (
    .clk          (clk),
    .rst_n        (rst_sn),
    .clr_i        (scan_clr),
    .en_i         (scan_en),
    .bit_i        (scan_sh[0]),
    .idx_i        (idx_q),
    .run_o        (run_w),
    .best_cnt_o   (best_cnt_w),
    .best_start_o (best_start_w)
  );

  tws_pick #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(MIN_RUN)) u_pick (
    .n_i          (n_q),
    .half_i       (half_q),
    .run_i        (run_w),
    .best_cnt_i   (best_cnt_w),
    .best_start_i (best_start_w),
    .tap_o        (pick_tap),
    .ok_o         (pick_ok)
  );

  assign accept   = start_i && (state_q == TWS_IDLE);
  assign last_idx = IW'({n_q, 1'b0}) - IW'(1);

  always_comb begin
    state_d  = state_q;
    raw_d    = raw_q;
    merged_d = merged_q;
    n_d      = n_q;
    half_d   = half_q;
    idx_d    = idx_q;
    tap_d    = tap_q;
    err_d    = err_q;
    ren_d    = ren_q;
    done_d   = 1'b0;
    unique case (state_q)
      TWS_IDLE: begin
        if (accept) begin
          raw_d   = bitmap_i;
          n_d     = tap_count_i;
          half_d  = hs400_4tap_i;
          err_d   = 1'b0;
          ren_d   = 1'b0;
          state_d = TWS_MERGE;
        end
      end
      TWS_MERGE: begin
        merged_d = merged_w;
        idx_d    = '0;
        state_d  = TWS_SCAN;
      end
      TWS_SCAN: begin
        idx_d = idx_q + IW'(1);
        if (idx_q == last_idx) state_d = TWS_FINAL;
      end
      TWS_FINAL: begin
        done_d  = 1'b1;
        state_d = TWS_IDLE;
        if (pick_ok) begin
          tap_d = pick_tap;
          ren_d = 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      default: state_d = TWS_IDLE;
    endcase

    if (accept)                rerr_d = 1'b0;
    else if (retune_err_set_i) rerr_d = 1'b1;
    else                       rerr_d = rerr_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= TWS_IDLE;
      raw_q    <= '0;
      merged_q <= '0;
      n_q      <= '0;
      half_q   <= 1'b0;
      idx_q    <= '0;
      tap_q    <= '0;
      err_q    <= 1'b0;
      ren_q    <= 1'b0;
      done_q   <= 1'b0;
      rerr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      raw_q    <= raw_d;
      merged_q <= merged_d;
      n_q      <= n_d;
      half_q   <= half_d;
      idx_q    <= idx_d;
      tap_q    <= tap_d;
      err_q    <= err_d;
      ren_q    <= ren_d;
      done_q   <= done_d;
      rerr_q   <= rerr_d;
    end
  end

  assign busy_o       = state_q != TWS_IDLE;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign tap_set_o    = tap_q;
  assign retune_en_o  = ren_q;
  assign retune_err_o = rerr_q;
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
  parameter  int MAX_TAPS = 8,
  localparam int NW       = $clog2(MAX_TAPS + 1),
  localparam int IW       = $clog2(2 * MAX_TAPS + 1),
  localparam int TW       = $clog2(MAX_TAPS),
  localparam int CW       = IW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [NW-1:0] tap_count_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [TW-1:0] tap_set_o,
  input logic          retune_en_o,
  input logic          retune_err_o
);
  logic [CW-1:0] cyc_q;
  logic [NW-1:0] n_cap_q;
  logic          taken;

  assign taken = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      n_cap_q <= '0;
    end else if (taken) begin
      cyc_q   <= '0;
      n_cap_q <= tap_count_i;
    end else if (busy_o) begin
      cyc_q   <= cyc_q + CW'(1);
    end
  end

  // R9
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == CW'({n_cap_q, 1'b0}) + CW'(2)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (busy_o && !retune_err_o && !retune_en_o && !err_o));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (!retune_en_o && $stable(tap_set_o)));

  // R7
  ok_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> retune_en_o);

  // R7
  ren_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retune_en_o) |-> done_o);

  // R5
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (NW'(tap_set_o) < n_cap_q));
endmodule

bind tap_window_sel tws_chk #(.MAX_TAPS(MAX_TAPS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .start_i      (start_i),
  .tap_count_i  (tap_count_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .tap_set_o    (tap_set_o),
  .retune_en_o  (retune_en_o),
  .retune_err_o (retune_err_o)
);

// File: tb/tap_window_sel_tb.sv
`timescale 1ns/1ps
module tap_window_sel_tb;
  localparam int MAX_TAPS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  tap_count_i;
  logic        hs400_4tap_i;
  logic [15:0] bitmap_i;
  logic        retune_err_set_i;
  logic        busy_o, done_o, err_o, retune_en_o, retune_err_o;
  logic [2:0]  tap_set_o;

  int checks = 0;
  int fails  = 0;
  int last_tap = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tap_window_sel #(.MAX_TAPS(MAX_TAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tap_count_i(tap_count_i),
    .hs400_4tap_i(hs400_4tap_i), .bitmap_i(bitmap_i),
    .retune_err_set_i(retune_err_set_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .tap_set_o(tap_set_o), .retune_en_o(retune_en_o),
    .retune_err_o(retune_err_o)
  );

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] bm, input int n, input bit half,
                                output bit ok, output int tap);
    bit m[16];
    int best = 0, bst = 0, run = 0;
    for (int i = 0; i < 2 * n; i++) m[i] = bm[i % n] & bm[(i % n) + n];
    for (int i = 0; i < 2 * n; i++) begin
      if (m[i]) run++;
      else begin
        if (run > best) begin best = run; bst = i - run; end
        run = 0;
      end
    end
    if (run > best) begin best = run; bst = 2 * n - run; end
    ok  = best >= 3;
    tap = ((2 * bst + best - 1) / 2) % n;
    if (half) tap = tap / 2;
  endfunction

  task automatic run_case(input logic [15:0] bm, input int n, input bit half,
                          input bit poke, input bit want_rerr_clr, input string tag);
    bit ok;
    int tap, exp_tap, edges;
    model(bm, n, half, ok, tap);
    exp_tap = ok ? tap : last_tap;
    @(negedge clk);
    bitmap_i = bm; tap_count_i = 4'(n); hs400_4tap_i = half; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (want_rerr_clr) chk(retune_err_o == 1'b0, "R8", "retune_err after start", retune_err_o, 0);
    if (poke) begin
      start_i = 1'b1; bitmap_i = 16'hFFFF; tap_count_i = 4'd4; hs400_4tap_i = !half;
    end
    edges = 0;
    while (edges < 40 && !done_o) begin
      @(negedge clk);
      start_i = 1'b0;
      edges++;
    end
    chk(edges == 2 * n + 2, "R9", "done latency", edges, 2 * n + 2);
    chk(err_o == !ok && tap_set_o == 3'(exp_tap) && retune_en_o == ok, tag,
        "tap/err/ren", {29'(tap_set_o), err_o, retune_en_o}, {29'(exp_tap), !ok, ok});
    last_tap = exp_tap;
    @(negedge clk);
    if (poke) chk(!busy_o && !done_o, "R10", "busy after poked scan", busy_o, 0);
    else      chk(!done_o, "R9", "done pulse width", done_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; tap_count_i = 4'd8; hs400_4tap_i = 1'b0;
    bitmap_i = '0; retune_err_set_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({busy_o, done_o, err_o, retune_en_o, retune_err_o, tap_set_o} == '0, "R11",
        "reset outputs", {busy_o, done_o, err_o, retune_en_o, retune_err_o, tap_set_o}, 0);

    // R5 wrap: taps 6,7,0 pass -> run 6..8 -> tap 7
    run_case(16'hC1C1, 8, 0, 0, 0, "R5");
    // R4 error keeps tap 7
    run_case(16'h0505, 8, 0, 0, 0, "R4");
    chk(tap_set_o == 3'd7, "R4", "tap kept on error", tap_set_o, 7);
    // R3 tie: runs 0..2 and 4..6 -> tap 1
    run_case(16'h7777, 8, 0, 0, 0, "R3");
    // R2 tail: all pass for N=4 -> tap 3
    run_case(16'h00FF, 4, 0, 0, 0, "R2");
    // R1 one probe of tap 1 fails in second pass only
    run_case(16'hFDFF, 8, 0, 0, 0, "R1");
    // R6 halving variant
    run_case(16'h00EE, 4, 1, 0, 0, "R6");
    // R10 start while busy ignored
    run_case(16'h0F0F, 8, 0, 1, 0, "R10");

    // R8 flag set, held, cleared by start
    @(negedge clk); retune_err_set_i = 1'b1;
    @(negedge clk); retune_err_set_i = 1'b0;
    chk(retune_err_o == 1'b1, "R8", "retune_err set", retune_err_o, 1);
    repeat (3) @(negedge clk);
    chk(retune_err_o == 1'b1, "R8", "retune_err held", retune_err_o, 1);
    run_case(16'h3C3C, 8, 0, 0, 1, "R8");

    // Exhaustive N=4, both variants: R1/R2/R3/R4/R5/R6/R7
    for (int h = 0; h < 2; h++)
      for (int b = 0; b < 256; b++)
        run_case(16'(b), 4, h[0], 0, 0, "R1/R2/R3/R5/R6/R7");

    // Dense random N=8: R1/R2/R4/R5/R7
    for (int k = 0; k < 400; k++) begin
      logic [15:0] v;
      v = 16'($urandom) | 16'($urandom);
      if (k % 3 == 0) v = v | 16'($urandom);
      run_case(v, 8, k[0] & k[1], 0, 0, "R1/R2/R4/R5/R7");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule